// File: doc/BRIEF.md
# Shared Memory Access Multiplexer

This block lets up to eight requesters share one 12-bit memory with a 4096-word address space. The requesters can be processors, which fetch instructions and data through their port, or controllers, which move data only. A requester raises its request with an address, a direction bit and, for a write, a data word. The block grants one port at a time and runs the memory cycle. It then pulses that port's acknowledge. On a read, the word is on the shared read-data output while the acknowledge is high.

A port can also ask for "the next word of a block" instead of giving an address. In this three-cycle block mode, each port owns two reserved memory words at `BLK_BASE + 2*port` and `BLK_BASE + 2*port + 1`. The first holds a two's-complement word count and the second holds the current address. The block increments the count, then increments the address, and then moves the data at the new address. A count that rolls over to zero marks the last word and raises a one-cycle done pulse for that port.

Top module: `mem_port_mux`

## Requirements
- R1: After reset, `ack_o`, `done_o` and `rdata_o` are all zero.
- R2: In a single-word read, `ack_o[p]` is high for exactly one cycle, three clock edges after the edge at which the request is taken. While it is high, `rdata_o` holds the memory word at the given address.
- R3: A single-word write (`we_i[p]`=1) stores `wdata_i[p]` at `addr_i[p]`. A later read of that address returns the stored word, and the write also acknowledges after three edges.
- R4: When several ports request in the same cycle, the lowest-numbered port is served first. A higher-numbered port that keeps its request is served afterwards.
- R5: No more than one acknowledge bit is high at a time, and each transfer completes before the next grant.
- R6: In block mode (`blk_i[p]`=1) the block adds one to the word at `BLK_BASE+2p` and adds one to the word at `BLK_BASE+2p+1`. It then reads or writes the data word at that incremented address, and `addr_i[p]` has no effect.
- R7: In block mode, `done_o[p]` pulses together with `ack_o[p]` exactly when the incremented word count equals zero. A single-word transfer never raises `done_o`.
- R8: A block-mode transfer acknowledges seven clock edges after the edge at which the request is taken.
- R9: `rdata_o` changes only on read acknowledges. A write leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NPORTS | Request per port, held until acknowledged |
| blk_i | input | NPORTS | Per port: 1 = three-cycle block mode |
| we_i | input | NPORTS | Per port: 1 = write, 0 = read |
| addr_i | input | NPORTS*AW | Word address per port (port p at bits p*AW upward) |
| wdata_i | input | NPORTS*DW | Write data per port (port p at bits p*DW upward) |
| ack_o | output | NPORTS | One-cycle acknowledge per port |
| done_o | output | NPORTS | One-cycle block-complete pulse per port |
| rdata_o | output | DW | Read data, valid with a read acknowledge |

## Verification
Single reads and writes from a low-numbered port set up known memory contents, and read-back shows whether the write path and the read latency are right. Two simultaneous requests from different ports show whether the priority order is correct and whether the losing port is still served. Block transfers on one port start from a preset count of minus two. The first transfer must not raise done and the second must, and both must leave incremented count and address words in memory. These runs also carry a garbage address input, which shows that the reserved pointer is used and the port address is not. A write placed between two reads shows that the read-data output holds its value.

// File: rtl/mem_port_mux_pkg.sv
package mem_port_mux_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WC_RD = 3'd1,
    ST_WC_WR = 3'd2,
    ST_CA_RD = 3'd3,
    ST_CA_WR = 3'd4,
    ST_XFER  = 3'd5,
    ST_FIN   = 3'd6,
    ST_ACK   = 3'd7
  } seq_state_t;
endpackage

// File: rtl/mpm_arbiter.sv
module mpm_arbiter #(
  parameter int NPORTS = 8,
  localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPORTS-1:0] req_i,
  output logic              any_o,
  output logic [PW-1:0]     idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = NPORTS - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = PW'(i);
      end
    end
  end

  // R4: the chosen index always points at a requesting port
  p_gnt_hit_r4: assert property (@(posedge clk) disable iff (rst)
    any_o |-> req_i[idx_o]);
endmodule

// File: rtl/mpm_ram.sv
module mpm_ram #(
  parameter int DW = 12,
  parameter int AW = 12,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= din;
    dout <= mem[addr];
  end
endmodule

// File: rtl/mpm_sequencer.sv
module mpm_sequencer
  import mem_port_mux_pkg::*;
#(
  parameter int NPORTS = 8,
  parameter int DW = 12,
  parameter int AW = 12,
  parameter logic [AW-1:0] BLK_BASE = AW'(16),
  localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 any_i,
  input  logic [PW-1:0]        idx_i,
  input  logic [NPORTS-1:0]    blk_i,
  input  logic [NPORTS-1:0]    we_i,
  input  logic [NPORTS*AW-1:0] addr_i,
  input  logic [NPORTS*DW-1:0] wdata_i,
  input  logic [DW-1:0]        ram_dout,
  output logic                 ram_we,
  output logic [AW-1:0]        ram_addr,
  output logic [DW-1:0]        ram_din,
  output logic [NPORTS-1:0]    ack_o,
  output logic [NPORTS-1:0]    done_o,
  output logic [DW-1:0]        rdata_o
);
  seq_state_t          state_q;
  logic [PW-1:0]       port_q;
  logic                blk_q, wr_q, zero_q;
  logic [AW-1:0]       ca_q;
  logic [AW-1:0]       wc_addr, ca_addr, sel_addr;
  logic [DW-1:0]       sel_wdata, dout_inc;
  logic [NPORTS-1:0]   port_oh;

  assign sel_addr  = addr_i[port_q*AW +: AW];
  assign sel_wdata = wdata_i[port_q*DW +: DW];
  assign wc_addr   = BLK_BASE + (AW'(port_q) << 1);
  assign ca_addr   = wc_addr + AW'(1);
  assign dout_inc  = ram_dout + DW'(1);
  assign port_oh   = NPORTS'(1) << port_q;

  always_comb begin
    ram_we   = 1'b0;
    ram_addr = wc_addr;
    ram_din  = dout_inc;
    unique case (state_q)
      ST_WC_RD: ram_addr = wc_addr;
      ST_WC_WR: begin ram_addr = wc_addr; ram_we = 1'b1; end
      ST_CA_RD: ram_addr = ca_addr;
      ST_CA_WR: begin ram_addr = ca_addr; ram_we = 1'b1; end
      ST_XFER: begin
        ram_addr = blk_q ? ca_q : sel_addr;
        ram_we   = we_i[port_q];
        ram_din  = sel_wdata;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      port_q  <= '0;
      blk_q   <= 1'b0;
      wr_q    <= 1'b0;
      zero_q  <= 1'b0;
      ca_q    <= '0;
      ack_o   <= '0;
      done_o  <= '0;
      rdata_o <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (any_i) begin
          port_q  <= idx_i;
          blk_q   <= blk_i[idx_i];
          state_q <= blk_i[idx_i] ? ST_WC_RD : ST_XFER;
        end
        ST_WC_RD: state_q <= ST_WC_WR;
        ST_WC_WR: begin
          zero_q  <= (dout_inc == '0);
          state_q <= ST_CA_RD;
        end
        ST_CA_RD: state_q <= ST_CA_WR;
        ST_CA_WR: begin
          ca_q    <= dout_inc[AW-1:0];
          state_q <= ST_XFER;
        end
        ST_XFER: begin
          wr_q    <= we_i[port_q];
          state_q <= ST_FIN;
        end
        ST_FIN: begin
          ack_o   <= port_oh;
          done_o  <= (blk_q && zero_q) ? port_oh : '0;
          if (!wr_q) rdata_o <= ram_dout;
          state_q <= ST_ACK;
        end
        ST_ACK: begin
          ack_o   <= '0;
          done_o  <= '0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R5: at most one port acknowledged
  p_ack_single_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack_o));
  // R2: acknowledge lasts exactly one cycle
  p_ack_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    (|ack_o) |=> (ack_o == '0));
  // R7: done only accompanies the same port's acknowledge
  p_done_with_ack_r7: assert property (@(posedge clk) disable iff (rst)
    ((done_o & ~ack_o) == '0));
  // R9: read data moves only when an acknowledge appears
  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (ack_o == '0) |-> $stable(rdata_o) or $rose(|ack_o));
  // R5: memory is never written while no transfer is active
  p_no_idle_write_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> !ram_we);
endmodule

// File: rtl/mem_port_mux.sv
module mem_port_mux #(
  parameter int NPORTS = 8,
  parameter int DW = 12,
  parameter int AW = 12,
  parameter logic [AW-1:0] BLK_BASE = AW'(16),
  localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NPORTS-1:0]    req_i,
  input  logic [NPORTS-1:0]    blk_i,
  input  logic [NPORTS-1:0]    we_i,
  input  logic [NPORTS*AW-1:0] addr_i,
  input  logic [NPORTS*DW-1:0] wdata_i,
  output logic [NPORTS-1:0]    ack_o,
  output logic [NPORTS-1:0]    done_o,
  output logic [DW-1:0]        rdata_o
);
  logic          any_req;
  logic [PW-1:0] win_idx;
  logic          ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_din, ram_dout;

  mpm_arbiter #(.NPORTS(NPORTS)) arb_i (
    .clk(clk), .rst(rst), .req_i(req_i), .any_o(any_req), .idx_o(win_idx)
  );

  mpm_sequencer #(
    .NPORTS(NPORTS), .DW(DW), .AW(AW), .BLK_BASE(BLK_BASE)
  ) seq_i (
    .clk(clk), .rst(rst), .any_i(any_req), .idx_i(win_idx),
    .blk_i(blk_i), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .ram_dout(ram_dout), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_din(ram_din), .ack_o(ack_o), .done_o(done_o), .rdata_o(rdata_o)
  );

  mpm_ram #(.DW(DW), .AW(AW)) ram_i (
    .clk(clk), .we(ram_we), .addr(ram_addr), .din(ram_din), .dout(ram_dout)
  );
endmodule

// File: tb/mem_port_mux_tb_top.sv
module mem_port_mux_tb_top;
  localparam int NP = 8, DW = 12, AW = 12;
  localparam int BASE = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic [NP-1:0] req = '0, blk = '0, we = '0;
  logic [NP*AW-1:0] addr = '0;
  logic [NP*DW-1:0] wdata = '0;
  logic [NP-1:0] ack, done;
  logic [DW-1:0] rdata;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  mem_port_mux #(.NPORTS(NP), .DW(DW), .AW(AW), .BLK_BASE(AW'(BASE))) dut_i (
    .clk(clk), .rst(rst), .req_i(req), .blk_i(blk), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .ack_o(ack), .done_o(done), .rdata_o(rdata)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one transfer on port p; returns latency, read data and done seen with ack
  task automatic xfer(input int p, input bit w, input bit b, input int a, input int d,
                      output int lat, output logic [DW-1:0] rd, output bit dn);
    @(negedge clk);
    we[p] = w; blk[p] = b;
    addr[p*AW +: AW] = AW'(a);
    wdata[p*DW +: DW] = DW'(d);
    req[p] = 1'b1;
    lat = 0; rd = '0; dn = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      lat++;
      if (ack[p]) break;
    end
    rd = rdata; dn = done[p];
    req[p] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(ack == '0, "R1 ack", int'(ack), 0);
    chk(done == '0, "R1 done", int'(done), 0);
    chk(rdata == '0, "R1 rdata", int'(rdata), 0);
  endtask

  task automatic t_single;
    int lat; logic [DW-1:0] rd; bit dn;
    xfer(0, 1, 0, 12'h200, 12'h3C5, lat, rd, dn);
    chk(lat == 3, "R3 write latency", lat, 3);
    chk(!dn, "R7 no done on single write", int'(dn), 0);
    xfer(1, 1, 0, 12'h201, 12'h0A7, lat, rd, dn);
    xfer(4, 0, 0, 12'h200, 0, lat, rd, dn);
    chk(lat == 3, "R2 read latency", lat, 3);
    chk(rd == 12'h3C5, "R2/R3 read data", int'(rd), 'h3C5);
    chk(!dn, "R7 no done on single read", int'(dn), 0);
    xfer(6, 0, 0, 12'h201, 0, lat, rd, dn);
    chk(rd == 12'h0A7, "R3 second word", int'(rd), 'h0A7);
    chk(ack == '0, "R2 ack pulse ended", int'(ack), 0);
  endtask

  task automatic t_hold;
    int lat; logic [DW-1:0] rd; bit dn;
    xfer(2, 0, 0, 12'h200, 0, lat, rd, dn);
    xfer(2, 1, 0, 12'h300, 12'h111, lat, rd, dn);
    chk(rd == 12'h3C5, "R9 rdata kept over write", int'(rd), 'h3C5);
  endtask

  task automatic t_priority;
    int n = 0, first = -1;
    @(negedge clk);
    we = '0; blk = '0;
    addr[5*AW +: AW] = 12'h201;
    addr[2*AW +: AW] = 12'h200;
    req[5] = 1'b1; req[2] = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (ack != '0) begin first = $clog2(int'(ack)); break; end
    end
    chk(first == 2, "R4 lowest port first", first, 2);
    chk(rdata == 12'h3C5, "R4 data for port 2", int'(rdata), 'h3C5);
    req[2] = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      n++;
      if (ack[5]) break;
    end
    chk(n == 4, "R4/R5 port 5 served next", n, 4);
    chk(rdata == 12'h0A7, "R4 data for port 5", int'(rdata), 'h0A7);
    req[5] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_block;
    int lat; logic [DW-1:0] rd; bit dn;
    xfer(0, 1, 0, BASE + 6, 12'hFFE, lat, rd, dn);
    xfer(0, 1, 0, BASE + 7, 12'h0FF, lat, rd, dn);
    xfer(0, 1, 0, 12'h100, 12'hABC, lat, rd, dn);
    xfer(3, 0, 1, 12'h777, 0, lat, rd, dn);
    chk(lat == 7, "R8 block latency", lat, 7);
    chk(rd == 12'hABC, "R6 block read at incremented address", int'(rd), 'hABC);
    chk(!dn, "R7 no done while count nonzero", int'(dn), 0);
    xfer(0, 0, 0, BASE + 6, 0, lat, rd, dn);
    chk(rd == 12'hFFF, "R6 count incremented", int'(rd), 'hFFF);
    xfer(0, 0, 0, BASE + 7, 0, lat, rd, dn);
    chk(rd == 12'h100, "R6 address incremented", int'(rd), 'h100);
    xfer(3, 1, 1, 12'h200, 12'h555, lat, rd, dn);
    chk(lat == 7, "R8 block write latency", lat, 7);
    chk(dn, "R7 done on count reaching zero", int'(dn), 1);
    xfer(0, 0, 0, 12'h101, 0, lat, rd, dn);
    chk(rd == 12'h555, "R6 block write landed", int'(rd), 'h555);
    xfer(0, 0, 0, 12'h200, 0, lat, rd, dn);
    chk(rd == 12'h3C5, "R6 port address ignored", int'(rd), 'h3C5);
    xfer(0, 0, 0, BASE + 6, 0, lat, rd, dn);
    chk(rd == 12'h000, "R7 count now zero", int'(rd), 0);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single();
    t_hold();
    t_priority();
    t_block();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule